// File: doc/BRIEF.md
# Genome Segment Netlist Decoder

This block turns a circular bit-string genome into a netlist description, one node at a time. The genome is held elsewhere and is read one 24-bit segment per request, addressed by segment number. After a start pulse the decoder fetches segments 0 through 100 in order. For each one it extracts a 3-bit node function and two input pointers, and converts each pointer into an absolute source node index.

A pointer gives a direction, an origin mode and a 6-bit step count. The step count is walked around the circle of 101 segments, either from the node's own position or from one end of the string. Each decoded node leaves on a valid/ready stream that carries the node number, its function, both source indices and a flag marking the ground node. Once the last node has been accepted, the block raises a done flag and waits for the next start pulse.

Top module: `genome_netlist_decoder`

## Requirements
- R1: After a start pulse the block requests segments by index from 0 to 100 in increasing order, holding `seg_req_valid` until `seg_rsp_valid` returns the word, and emits exactly one stream item per segment with `out_node` equal to the segment index.
- R2: `out_func` equals segment bits [7:5].
- R3: Segment bits [4:0] have no effect on any output.
- R4: Source A is decoded from bit 8 (direction), bit 9 (origin mode) and bits [15:10] (step count). Source B is decoded from bit 16 (direction), bit 17 (origin mode) and bits [23:18] (step count).
- R5: Direction 0 counts toward higher indices and direction 1 toward lower ones. Origin mode 1 starts from the current node's index. Origin mode 0 starts from index 0 when counting upward and from index 100 when counting downward.
- R6: Counting wraps past either end, so each source equals the origin plus or minus the step count, taken modulo 101. This holds exactly for every step count from 0 to 63 and every origin, and the result always lies between 0 and 100.
- R7: `out_ground` is 1 for node 0 and 0 for every other node, whatever function node 0 decodes to.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and all stream fields hold their values.
- R9: `done` rises in the cycle after node 100 is accepted and stays high with no requests or stream items. A start pulse clears it and begins a new pass. A start pulse during a pass is ignored.
- R10: After reset `out_valid`, `done` and `seg_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decoding pass when idle |
| done | output | 1 | Pass finished, held until the next start |
| seg_req_valid | output | 1 | Segment fetch request pending |
| seg_req_idx | output | 7 | Index of the requested segment |
| seg_rsp_valid | input | 1 | Requested segment word present |
| seg_rsp_data | input | 24 | Segment word |
| out_valid | output | 1 | Stream item present |
| out_ready | input | 1 | Consumer accepts the item |
| out_node | output | 7 | Node index of the item |
| out_func | output | 3 | Node function code |
| out_src_a | output | 7 | Resolved first source index |
| out_src_b | output | 7 | Resolved second source index |
| out_ground | output | 1 | Item is the ground node |

## Verification
The assertions check several properties on every cycle. Requested indices stay in range, each accepted item advances the node counter by one, items and their fields are held under backpressure, resolved sources stay below 101, the ground flag tracks node 0, and done rises only after node 100 is accepted. Whether each source equals the correct modular count can only be shown by the bench scenarios. These compare every item against a model, on random genomes and on directed wrap corners (step 63 from both ends, exact landings on 0 and 100). The bench scenarios also show that altering bits [4:0] leaves the stream unchanged and that a mid-pass start pulse changes nothing.

// File: rtl/gnd_pkg.sv
package gnd_pkg;
  localparam int JUNK_W  = 5;
  localparam int FUNC_W  = 3;
  localparam int LEN_W   = 6;
  localparam int NODE_W  = 7;
  localparam int NUM_PTR = 2;
  localparam int PTR_W   = 2 + LEN_W;
  localparam int FIELD_W = FUNC_W + NUM_PTR * PTR_W;
  localparam int SEG_W   = JUNK_W + FIELD_W;

  typedef struct packed {
    logic             back;
    logic             rel;
    logic [LEN_W-1:0] len;
  } ptr_field_t;

  typedef struct packed {
    ptr_field_t [NUM_PTR-1:0] ptr;
    logic [FUNC_W-1:0]        func;
  } seg_fields_t;
endpackage

// File: rtl/seg_unpack.sv
module seg_unpack
  import gnd_pkg::*;
(
  input  logic [FIELD_W-1:0] raw,
  output seg_fields_t        fld
);
  // raw bit 0 corresponds to segment bit JUNK_W
  assign fld.func = raw[FUNC_W-1:0];

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    localparam int BASE = FUNC_W + k * PTR_W;
    assign fld.ptr[k].back = raw[BASE];
    assign fld.ptr[k].rel  = raw[BASE + 1];
    assign fld.ptr[k].len  = raw[BASE + 2 +: LEN_W];
  end
endmodule

// File: rtl/ptr_resolve.sv
module ptr_resolve
  import gnd_pkg::*;
#(
  parameter int SEG_COUNT = 101
) (
  input  logic [NODE_W-1:0] cur,
  input  ptr_field_t        fld,
  output logic [NODE_W-1:0] src
);
  localparam int SUM_W = NODE_W + 1;
  localparam logic [SUM_W-1:0] MODN  = SUM_W'(SEG_COUNT);
  localparam logic [SUM_W-1:0] LASTI = SUM_W'(SEG_COUNT - 1);

  logic [SUM_W-1:0] origin;
  logic [SUM_W-1:0] step;
  logic [SUM_W-1:0] fwd;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    if (fld.rel)       origin = {1'b0, cur};
    else if (fld.back) origin = LASTI;
    else               origin = '0;
    step = SUM_W'(fld.len);
    fwd  = origin + step;
    if (!fld.back)
      wrapped = (fwd >= MODN) ? fwd - MODN : fwd;
    else
      wrapped = (origin >= step) ? origin - step : origin + MODN - step;
    src = NODE_W'(wrapped);
  end
endmodule

// File: rtl/decode_seq.sv
module decode_seq
  import gnd_pkg::*;
#(
  parameter int SEG_COUNT = 101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rsp_valid,
  input  logic              out_ready,
  output logic              fetch,
  output logic              capture,
  output logic [NODE_W-1:0] cur_idx,
  output logic              out_valid,
  output logic              done
);
  localparam logic [NODE_W-1:0] LAST = NODE_W'(SEG_COUNT - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EMIT} state_t;
  state_t state;

  assign fetch   = (state == S_FETCH);
  assign capture = fetch && rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_idx   <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cur_idx <= '0;
          done    <= 1'b0;
          state   <= S_FETCH;
        end
        S_FETCH: if (rsp_valid) begin
          out_valid <= 1'b1;
          state     <= S_EMIT;
        end
        S_EMIT: if (out_ready) begin
          out_valid <= 1'b0;
          if (cur_idx == LAST) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cur_idx <= cur_idx + 1'b1;
            state   <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_req_range_R1: assert property (@(posedge clk) disable iff (rst)
    fetch |-> cur_idx <= LAST);
  assert_seq_step_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && cur_idx != LAST) |=> cur_idx == NODE_W'($past(cur_idx) + 1'b1));
  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(out_valid && out_ready && cur_idx == LAST));
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!fetch && !out_valid));
endmodule

// File: rtl/out_stage.sv
module out_stage
  import gnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [NODE_W-1:0] cur_idx,
  input  logic [FUNC_W-1:0] func,
  input  logic [NODE_W-1:0] src_in [NUM_PTR],
  input  logic              out_valid,
  input  logic              out_ready,
  output logic [NODE_W-1:0] out_node,
  output logic [FUNC_W-1:0] out_func,
  output logic [NODE_W-1:0] out_src [NUM_PTR],
  output logic              out_ground
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_node   <= '0;
      out_func   <= '0;
      out_ground <= 1'b0;
    end else if (capture) begin
      out_node   <= cur_idx;
      out_func   <= func;
      out_ground <= (cur_idx == '0);
    end
  end

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)          out_src[k] <= '0;
      else if (capture) out_src[k] <= src_in[k];
    end
  end

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_node) && $stable(out_func) &&
      $stable(out_src[0]) && $stable(out_src[1]) && $stable(out_ground)));
  assert_ground_flag_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ground == (out_node == '0)));
endmodule

// File: rtl/genome_netlist_decoder.sv
module genome_netlist_decoder
  import gnd_pkg::*;
#(
  parameter int SEG_COUNT = 101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              seg_req_valid,
  output logic [NODE_W-1:0] seg_req_idx,
  input  logic              seg_rsp_valid,
  input  logic [SEG_W-1:0]  seg_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NODE_W-1:0] out_node,
  output logic [FUNC_W-1:0] out_func,
  output logic [NODE_W-1:0] out_src_a,
  output logic [NODE_W-1:0] out_src_b,
  output logic              out_ground
);
  logic              capture;
  logic [NODE_W-1:0] cur_idx;
  seg_fields_t       fld;
  logic [NODE_W-1:0] src_res [NUM_PTR];
  logic [NODE_W-1:0] src_reg [NUM_PTR];

  decode_seq #(.SEG_COUNT(SEG_COUNT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .rsp_valid(seg_rsp_valid),
    .out_ready(out_ready), .fetch(seg_req_valid), .capture(capture),
    .cur_idx(cur_idx), .out_valid(out_valid), .done(done)
  );

  assign seg_req_idx = cur_idx;

  seg_unpack u_unpack (
    .raw(seg_rsp_data[SEG_W-1:JUNK_W]),
    .fld(fld)
  );

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_res
    ptr_resolve #(.SEG_COUNT(SEG_COUNT)) u_res (
      .cur(cur_idx), .fld(fld.ptr[k]), .src(src_res[k])
    );
  end

  out_stage u_out (
    .clk(clk), .rst(rst), .capture(capture), .cur_idx(cur_idx),
    .func(fld.func), .src_in(src_res), .out_valid(out_valid),
    .out_ready(out_ready), .out_node(out_node), .out_func(out_func),
    .out_src(src_reg), .out_ground(out_ground)
  );

  assign out_src_a = src_reg[0];
  assign out_src_b = src_reg[1];

  assert_src_range_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_src_a < NODE_W'(SEG_COUNT) && out_src_b < NODE_W'(SEG_COUNT)));
  assert_rsp_known_R3: assert property (@(posedge clk) disable iff (rst)
    seg_rsp_valid |-> !$isunknown(seg_rsp_data));
endmodule

// File: tb/genome_netlist_decoder_bench.sv
`timescale 1ns/1ps
module genome_netlist_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       done, seg_req_valid, out_valid, out_ground;
  logic [6:0] seg_req_idx, out_node, out_src_a, out_src_b;
  logic       seg_rsp_valid = 1'b0;
  logic [23:0] seg_rsp_data = '0;
  logic       out_ready = 1'b0;
  logic [2:0] out_func;

  int n_checks = 0;
  int n_fail   = 0;
  logic [23:0] geno [0:100];

  always #2.5 clk = ~clk;

  genome_netlist_decoder u_genome_netlist_decoder (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .seg_req_valid(seg_req_valid), .seg_req_idx(seg_req_idx),
    .seg_rsp_valid(seg_rsp_valid), .seg_rsp_data(seg_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_node(out_node),
    .out_func(out_func), .out_src_a(out_src_a), .out_src_b(out_src_b),
    .out_ground(out_ground)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R5/R6 model: origin by mode and direction, then step around 101 positions
  function automatic int model_src(input int cur, input bit back, input bit rel, input int len);
    int org, r;
    org = rel ? cur : (back ? 100 : 0);
    r = back ? org - len : org + len;
    if (r < 0) r += 101;
    if (r > 100) r -= 101;
    return r;
  endfunction

  function automatic logic [23:0] mkseg(input int junk, input int fn,
      input bit ba, input bit ra, input int la, input bit bb, input bit rb, input int lb);
    logic [23:0] s;
    s[4:0] = junk[4:0]; s[7:5] = fn[2:0];
    s[8] = ba; s[9] = ra; s[15:10] = la[5:0];
    s[16] = bb; s[17] = rb; s[23:18] = lb[5:0];
    return s;
  endfunction

  task automatic fill_random();
    for (int i = 0; i <= 100; i++) geno[i] = 24'($urandom);
    geno[0]   = mkseg(31, 6, 1, 1, 63, 1, 0, 0);   // 0-63 -> 38 ; abs down 0 -> 100
    geno[1]   = mkseg(0, 1, 0, 0, 63, 1, 0, 63);   // abs up 63 -> 63 ; abs down 63 -> 37
    geno[37]  = mkseg(5, 2, 0, 1, 63, 1, 1, 37);   // 37+63 -> 100 ; 37-37 -> 0
    geno[38]  = mkseg(9, 3, 0, 1, 63, 1, 1, 39);   // 38+63 -> 0 ; 38-39 -> 100
    geno[100] = mkseg(17, 7, 0, 1, 63, 0, 1, 0);   // 100+63 -> 62 ; 100+0 -> 100
  endtask

  task automatic run_decode(input bit poke_start);
    int  seen = 0, cyc = 0, lat = 0, ridx = 0;
    bit  pend = 0, held = 0, poked = 0;
    logic [6:0] h_node, h_a, h_b;
    logic [2:0] h_func;
    logic [23:0] s;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9", "done cleared by start", int'(done), 0);
    forever begin
      @(negedge clk);
      cyc++;
      if (seg_rsp_valid) seg_rsp_valid = 1'b0;
      else if (pend) begin
        if (lat == 0) begin
          seg_rsp_valid = 1'b1; seg_rsp_data = geno[ridx]; pend = 0;
        end else lat--;
      end else if (seg_req_valid) begin
        pend = 1; ridx = int'(seg_req_idx); lat = $urandom_range(0, 2);
        chk("R1", "request index", ridx, seen);
      end
      start = (poke_start && seen == 50 && !poked);
      if (start) poked = 1;
      if (held) begin
        chk("R8", "valid held", int'(out_valid), 1);
        chk("R8", "node held", int'(out_node), int'(h_node));
        chk("R8", "func held", int'(out_func), int'(h_func));
        chk("R8", "src_a held", int'(out_src_a), int'(h_a));
        chk("R8", "src_b held", int'(out_src_b), int'(h_b));
        held = 0;
      end
      out_ready = ($urandom_range(0, 3) != 0);
      if (out_valid) begin
        if (out_ready) begin
          s = geno[seen];
          chk("R1", "node index", int'(out_node), seen);
          chk("R2", "function", int'(out_func), int'(s[7:5]));
          chk("R4", "src_a", int'(out_src_a), model_src(seen, s[8], s[9], int'(s[15:10])));
          chk("R5", "src_b", int'(out_src_b), model_src(seen, s[16], s[17], int'(s[23:18])));
          chk("R7", "ground flag", int'(out_ground), (seen == 0) ? 1 : 0);
          if (seen == 37) chk("R6", "exact 100", int'(out_src_a), 100);
          if (seen == 38) chk("R6", "wrap to 0", int'(out_src_a), 0);
          if (seen == 100) chk("R6", "wrap 163", int'(out_src_a), 62);
          seen++;
        end else begin
          held = 1; h_node = out_node; h_func = out_func; h_a = out_src_a; h_b = out_src_b;
        end
      end
      if (done) break;
      if (cyc > 5000) begin
        chk("R9", "pass finished", 0, 1);
        break;
      end
    end
    seg_rsp_valid = 1'b0;
    start = 1'b0;
    chk("R1", "items per pass", seen, 101);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid || seg_req_valid || !done) begin
        chk("R9", "quiet after done", 1, 0);
        break;
      end
    end
    chk("R9", "done held", int'(done), 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "out_valid after reset", int'(out_valid), 0);
    chk("R10", "done after reset", int'(done), 0);
    chk("R10", "req after reset", int'(seg_req_valid), 0);

    fill_random();
    run_decode(1'b0);
    // R3: same genome with different junk bits must decode identically
    for (int i = 0; i <= 100; i++) geno[i][4:0] = ~geno[i][4:0];
    run_decode(1'b1);       // also pokes start mid-pass (R9)
    fill_random();
    run_decode(1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule